// File: doc/BRIEF.md
# Floating-Point Round-to-Integer Unit

This block takes one IEEE-754 single-precision word per cycle and returns the integral value of that number, still encoded as a single-precision word. A 2-bit mode input chosen per beat selects the rounding direction: toward minus infinity, toward plus infinity, to nearest, or toward zero. The mode travels down the pipeline with its operand, so consecutive beats may use different modes.

A valid flag comes in with each word and goes out with each result. Two parameters set how many register stages sit before the rounding logic and how many sit after it. Both default to zero, which makes the unit purely combinational between its ports. The valid flag always passes through the same number of stages as the data.

Top module: `fp_round_int`

## Requirements
- R1: Mode code 2'b00 (the default code) rounds toward minus infinity. For example, -1.5 gives -2.0, 1.5 gives 1.0, and -0.3 gives -1.0.
- R2: Mode code 2'b01 rounds toward plus infinity. For example, 1.5 gives 2.0 and -1.5 gives -1.0.
- R3: Mode code 2'b10 rounds to the nearest integer, and ties go away from zero. For example, 2.5 gives 3.0, -0.5 gives -1.0, and 0.49 gives 0.0.
- R4: Mode code 2'b11 rounds toward zero. For example, -1.5 gives -1.0.
- R5: An input whose biased exponent (bits 30:23) is 150 or more and which is not a NaN comes out unchanged. This includes both infinities.
- R6: A NaN input (exponent 255, fraction nonzero) gives a NaN with the same sign, the quiet bit (bit 22) set, and fraction bits 21:0 kept.
- R7: The output sign always equals the input sign. A result of zero is a signed zero that carries the input's sign, so ceil(-0.3) gives -0.0.
- R8: out_valid goes high exactly IN_STAGES+OUT_STAGES clock edges after the matching in_valid. out_data in that cycle is the result for that input.
- R9: While rst_n is low, every pipeline stage holds no valid beat. out_valid is low during reset and in the cycle after reset releases, unless a new beat has entered.
- R10: The mode is sampled together with its operand, so beats back to back with different modes are each rounded under their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat is present |
| in_data | input | 32 | Single-precision operand |
| in_mode | input | 2 | Rounding direction: 00 down, 01 up, 10 nearest/away, 11 toward zero |
| out_valid | output | 1 | Result beat is present |
| out_data | output | 32 | Integral value in single precision |

## Verification
Directed operands cover several distinct cases: values halfway between two integers, values a small step either side of a half, small magnitudes below one, signed zeros, denormals, infinities and NaNs. The halfway values separate nearest-with-ties-away from the three directed modes. The small magnitudes show whether a zero result keeps its sign or becomes plus or minus one. An operand just below 2^23 that rounds up shows whether the carry out of the significand bumps the exponent. Random operands with exponents spread around the integral boundary, mixed with random modes and gaps between beats, are run through a pipelined instance and a combinational instance at the same time, which exercises latency alignment and the mode travelling with each beat.

// File: rtl/fp_round_int_pkg.sv
package fp_round_int_pkg;

    localparam int unsigned EXP_W   = 8;
    localparam int unsigned MAN_W   = 23;
    localparam int unsigned WORD_W  = 1 + EXP_W + MAN_W;
    localparam int unsigned BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int unsigned INT_EXP = BIAS + MAN_W;          // 150: all bits integral
    localparam int unsigned MODE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        RND_DOWN = 2'b00,
        RND_UP   = 2'b01,
        RND_NEAR = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] man;
    } fp_word_t;

endpackage

// File: rtl/fp_round_delay.sv
module fp_round_delay #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign out_vld = in_vld;
            assign out_dat = in_dat;
        end else begin : g_regs
            typedef struct packed {
                logic         vld;
                logic [W-1:0] dat;
            } slot_t;

            slot_t [DEPTH-1:0] pipe_d;
            slot_t [DEPTH-1:0] pipe_q;

            always_comb begin
                pipe_d[0].vld = in_vld;
                pipe_d[0].dat = in_dat;
                for (int i = 1; i < int'(DEPTH); i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign out_vld = pipe_q[DEPTH-1].vld;
            assign out_dat = pipe_q[DEPTH-1].dat;
        end
    endgenerate

endmodule

// File: rtl/fp_round_core.sv
module fp_round_core
    import fp_round_int_pkg::*;
(
    input  logic [WORD_W-1:0] x_word,
    input  logic [MODE_W-1:0] mode,
    output logic [WORD_W-1:0] y_word
);

    localparam int unsigned SIG_W = MAN_W + 1;
    localparam int unsigned SH_W  = $clog2(SIG_W + 1);

    fp_word_t          x;
    fp_word_t          y;
    rnd_mode_e         md;
    logic              is_nan;
    logic              is_big;
    logic              is_small;
    logic [SH_W-1:0]   shamt;
    logic [SIG_W-1:0]  step;
    logic [MAN_W-1:0]  mask;
    logic [MAN_W-1:0]  half_bit;
    logic              tail_nz;
    logic              half_set;
    logic              any_nz;
    logic              mid_up;
    logic              small_up;
    logic [SIG_W:0]    sum;

    function automatic logic bump(input rnd_mode_e m, input logic s,
                                  input logic frac_nz, input logic at_half);
        case (m)
            RND_DOWN: bump = s & frac_nz;
            RND_UP:   bump = ~s & frac_nz;
            RND_NEAR: bump = at_half;
            default:  bump = 1'b0;
        endcase
    endfunction

    always_comb begin
        x        = fp_word_t'(x_word);
        md       = rnd_mode_e'(mode);
        is_nan   = (x.expo == '1) && (x.man != '0);
        is_big   = x.expo >= EXP_W'(INT_EXP);
        is_small = x.expo < EXP_W'(BIAS);

        // number of fraction bits inside the significand (1..23 in mid range)
        shamt    = SH_W'(EXP_W'(INT_EXP) - x.expo);
        step     = SIG_W'(1) << shamt;
        mask     = MAN_W'(step - SIG_W'(1));
        half_bit = mask ^ (mask >> 1);
        tail_nz  = |(x.man & mask);
        half_set = |(x.man & half_bit);
        mid_up   = bump(md, x.sign, tail_nz, half_set);
        sum      = {1'b0, 1'b1, x.man & ~mask} + (mid_up ? {1'b0, step} : '0);

        any_nz   = |{x.expo, x.man};
        small_up = bump(md, x.sign, any_nz, x.expo == EXP_W'(BIAS - 1));

        y = x;
        if (is_nan) begin
            y.man[MAN_W-1] = 1'b1;
        end else if (is_big) begin
            y = x;
        end else if (is_small) begin
            y.expo = small_up ? EXP_W'(BIAS) : '0;
            y.man  = '0;
        end else if (sum[SIG_W]) begin
            y.expo = x.expo + EXP_W'(1);
            y.man  = sum[MAN_W:1];
        end else begin
            y.man  = sum[MAN_W-1:0];
        end
    end

    assign y_word = y;

endmodule

// File: rtl/fp_round_int.sv
module fp_round_int
    import fp_round_int_pkg::*;
#(
    parameter int unsigned IN_STAGES  = 0,
    parameter int unsigned OUT_STAGES = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [31:0]       out_data
);

    localparam int unsigned IN_W = WORD_W + MODE_W;

    logic              core_vld;
    logic [IN_W-1:0]   core_pack;
    logic [WORD_W-1:0] core_x;
    logic [MODE_W-1:0] core_mode;
    logic [WORD_W-1:0] core_y;

    fp_round_delay #(.W(IN_W), .DEPTH(IN_STAGES)) u_in_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_valid),
        .in_dat  ({in_mode, in_data}),
        .out_vld (core_vld),
        .out_dat (core_pack)
    );

    assign core_x    = core_pack[WORD_W-1:0];
    assign core_mode = core_pack[IN_W-1:WORD_W];

    fp_round_core u_core (
        .x_word (core_x),
        .mode   (core_mode),
        .y_word (core_y)
    );

    fp_round_delay #(.W(WORD_W), .DEPTH(OUT_STAGES)) u_out_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (core_vld),
        .in_dat  (core_y),
        .out_vld (out_valid),
        .out_dat (out_data)
    );

endmodule

// File: rtl/fp_round_int_chk.sv
module fp_round_int_chk #(
    parameter int unsigned LAT = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic        core_vld,
    input logic [31:0] core_x,
    input logic [1:0]  core_mode,
    input logic [31:0] core_y
);

    function automatic logic nan_of(input logic [31:0] w);
        nan_of = (w[30:23] == 8'hFF) && (w[22:0] != '0);
    endfunction

    function automatic logic integral_of(input logic [31:0] w);
        int unsigned fb;
        if (w[30:23] >= 8'd150)      integral_of = 1'b1;
        else if (w[30:23] < 8'd127)  integral_of = (w[30:0] == '0);
        else begin
            fb = 150 - int'(w[30:23]);
            integral_of = ((w[22:0] << (23 - fb)) & 23'h7FFFFF) == '0;
        end
    endfunction

    int pend_q;
    int pend_d;

    always_comb begin
        pend_d = pend_q + (in_valid ? 1 : 0) - (out_valid ? 1 : 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 0;
        else        pend_q <= pend_d;
    end

    // R8: never more beats in flight than stages, never an output without a beat
    assert_inflight_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_d <= int'(LAT) && pend_d >= 0);
    assert_no_orphan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pend_q > 0 || in_valid));

    generate
        if (LAT > 0) begin : g_rst
            assert_reset_idle_R9: assert property (@(posedge clk)
                !rst_n |=> !out_valid);
        end
    endgenerate

    assert_nan_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld && nan_of(core_x)) |->
        (nan_of(core_y) && core_y[22] && core_y[21:0] == core_x[21:0]));
    assert_big_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld && !nan_of(core_x) && core_x[30:23] >= 8'd150) |-> core_y == core_x);
    assert_sign_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_vld |-> core_y[31] == core_x[31]);
    assert_integral_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld && !nan_of(core_x)) |-> integral_of(core_y));
    assert_floor_below_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld && !nan_of(core_x) && core_mode == 2'b00) |->
        (core_x[31] ? core_y[30:0] >= core_x[30:0] : core_y[30:0] <= core_x[30:0]));
    assert_ceil_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld && !nan_of(core_x) && core_mode == 2'b01) |->
        (core_x[31] ? core_y[30:0] <= core_x[30:0] : core_y[30:0] >= core_x[30:0]));
    assert_fix_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld && !nan_of(core_x) && core_mode == 2'b11) |->
        core_y[30:0] <= core_x[30:0]);

endmodule

bind fp_round_int fp_round_int_chk #(.LAT(IN_STAGES + OUT_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .core_vld  (core_vld),
    .core_x    (core_x),
    .core_mode (core_mode),
    .core_y    (core_y)
);

// File: tb/fp_round_int_test.sv
module fp_round_int_test;

    localparam int CLK_PER = 10;
    localparam int IN_A    = 1;
    localparam int OUT_A   = 2;
    localparam int LAT_A   = IN_A + OUT_A;

    typedef struct {
        int          due;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_mode = '0;
    logic        va, vb;
    logic [31:0] da, db;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    exp_t qa[$];
    exp_t qb[$];

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fp_round_int #(.IN_STAGES(IN_A), .OUT_STAGES(OUT_A)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_mode(in_mode), .out_valid(va), .out_data(da));

    fp_round_int uut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_mode(in_mode), .out_valid(vb), .out_data(db));

    // behavioural model: integer part and remainder, then renormalise
    function automatic logic [31:0] ref_round(input logic [31:0] x, input logic [1:0] md);
        logic   s = x[31];
        int     e = int'(x[30:23]);
        longint mant, ip, rem, halfv;
        int     sh, p;
        if (e == 255 && x[22:0] != 0) return {s, 8'hFF, 1'b1, x[21:0]};
        if (e >= 150) return x;
        mant = (e == 0) ? longint'(x[22:0]) : (longint'(1) << 23) + longint'(x[22:0]);
        sh   = (e == 0) ? 149 : 150 - e;
        if (sh > 40) begin
            ip = 0; rem = mant; halfv = longint'(1) << 40;
        end else begin
            ip    = mant >> sh;
            rem   = mant & ((longint'(1) << sh) - 1);
            halfv = longint'(1) << (sh - 1);
        end
        case (md)
            2'b00: if (s && rem != 0) ip++;
            2'b01: if (!s && rem != 0) ip++;
            2'b10: if (rem >= halfv) ip++;
            default: ;
        endcase
        if (ip == 0) return {s, 31'b0};
        p = 0;
        for (int b = 0; b < 40; b++) if (ip[b]) p = b;
        if (p > 23) ip = ip >> (p - 23);
        else        ip = ip << (23 - p);
        return {s, 8'(127 + p), ip[22:0]};
    endfunction

    function automatic string tag_of(input logic [31:0] x, input logic [1:0] md);
        logic [31:0] r = ref_round(x, md);
        if (x[30:23] == 8'hFF && x[22:0] != 0) return "R6";
        if (x[30:23] >= 8'd150) return "R5";
        if (r[30:0] == 0) return "R7";
        case (md)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, exp_v, cyc);
        end
    endtask

    task automatic compare_all();
        exp_t e;
        logic ea, eb;
        ea = qa.size() > 0 && qa[0].due == cyc;
        eb = qb.size() > 0 && qb[0].due == cyc;
        chk("R8", {31'b0, va}, {31'b0, ea});
        chk("R8", {31'b0, vb}, {31'b0, eb});
        if (ea) begin e = qa.pop_front(); if (va) chk(e.tag, da, e.val); end
        if (eb) begin e = qb.pop_front(); if (vb) chk(e.tag, db, e.val); end
    endtask

    task automatic step(input logic v, input logic [31:0] x, input logic [1:0] md,
                        input string tag = "");
        exp_t e;
        @(negedge clk);
        in_valid = v;
        in_data  = x;
        in_mode  = md;
        if (v) begin
            e.val = ref_round(x, md);
            e.tag = (tag == "") ? tag_of(x, md) : tag;
            e.due = cyc + LAT_A; qa.push_back(e);
            e.due = cyc;         qb.push_back(e);
        end
        #(CLK_PER/4);
        compare_all();
    endtask

    task automatic drain();
        for (int i = 0; i < LAT_A + 2; i++) step(1'b0, 32'h0, 2'b00);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    localparam logic [31:0] OPS [20] = '{
        32'h3FC00000, 32'hBFC00000, 32'h40200000, 32'hC0200000, 32'h3E99999A,
        32'hBE99999A, 32'h3F000000, 32'hBF000000, 32'h00000000, 32'h80000000,
        32'h7F800000, 32'hFF800000, 32'h7F800001, 32'hFF812345, 32'h4AFFFFFF,
        32'h501502F9, 32'h3F7FFFFF, 32'h00000001, 32'h3EFAE148, 32'hCAFFFFFF};

    initial begin
        logic [31:0] r;
        // R9: reset holds every stage empty
        repeat (3) @(negedge clk);
        chk("R9", {31'b0, va}, 32'h0);
        chk("R9", {31'b0, vb}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PER/4);
        chk("R9", {31'b0, va}, 32'h0);

        // spot values computed from the requirement text
        r = ref_round(32'hBE99999A, 2'b00); chk("R1", r, 32'hBF800000);
        r = ref_round(32'hBE99999A, 2'b01); chk("R7", r, 32'h80000000);
        r = ref_round(32'h40200000, 2'b10); chk("R3", r, 32'h40400000);
        r = ref_round(32'hBFC00000, 2'b11); chk("R4", r, 32'hBF800000);
        r = ref_round(32'h3FC00000, 2'b01); chk("R2", r, 32'h40000000);

        // directed operands under every mode
        for (int m = 0; m < 4; m++)
            foreach (OPS[i]) step(1'b1, OPS[i], 2'(m));
        drain();

        // R10: back-to-back beats on one operand, mode changing every beat
        step(1'b1, 32'hBFC00000, 2'b00, "R10");
        step(1'b1, 32'hBFC00000, 2'b01, "R10");
        step(1'b1, 32'hBFC00000, 2'b10, "R10");
        step(1'b1, 32'hBFC00000, 2'b11, "R10");
        drain();

        // random operands around the integral boundary, gaps between beats
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x;
            x = $urandom;
            x[30:23] = 8'(118 + ($urandom % 40));
            if ($urandom % 16 == 0) x[30:23] = 8'hFF;
            step(($urandom % 4) != 0, x, 2'($urandom));
        end
        drain();

        // R9: reset while beats are in flight discards them
        step(1'b1, 32'h3FC00000, 2'b00, "R9");
        step(1'b1, 32'h40200000, 2'b00, "R9");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        qa.delete();
        qb.delete();
        @(negedge clk);
        #(CLK_PER/4);
        chk("R9", {31'b0, va}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drain();

        done = 1;
        summary();
        $finish;
    end

endmodule